// File: doc/BRIEF.md
# Memory Region Coprocessor Scoreboard

This block keeps a small table of outstanding array operations. Each operation copies one source memory block to one destination memory block. Both blocks share one power-of-two size, given as a log2 exponent. The processor keeps running its own loads and stores while these operations execute. The scoreboard compares every processor access, and every newly issued array operation, against the regions that are still busy. A combinational stall or refusal then keeps the visible order of memory effects sequential.

An issue request carries a function number. It is accepted only when all four of these hold:
- the function is resident in one of the loaded contexts;
- the table has a free slot;
- the request has no ordering hazard with any in-flight operation;
- it is offered while the block is out of reset.

A context-load port brings functions into the resident set, and the least recently used context is replaced. A completion port frees an entry by index. The freed entry stops blocking in the same cycle, and that slot can be reused in the same cycle.

Top module: `region_scoreboard`

## Requirements
- R1: Reset empties the operation table and the resident-context set. After reset no access stalls, and an issue of any function is refused with a context miss.
- R2: A processor load (cpu_is_store=0) stalls when its address lies in the destination region of a live entry. A processor store (cpu_is_store=1) stalls when its address lies in the source or the destination region of a live entry. A load inside a source region alone does not stall.
- R3: A region with base B and exponent L covers every address A for which A and B agree in all bits at position L and above. Two regions are compared using the larger of their two exponents.
- R4: An issue is refused when any of the following overlaps the matching region of a live entry: its source with that entry's destination, its destination with that entry's source, or its destination with that entry's destination. Source-to-source overlap alone is allowed.
- R5: The table holds NUM_OPS entries (4 by default). An accepted issue takes the lowest-numbered free slot, and iss_slot reports that slot. When no slot is free, the issue is refused.
- R6: A completion (done_valid with done_idx) stops the named entry from blocking in that same cycle. A same-cycle issue may take the freed slot. Other entries are unaffected.
- R7: An issue whose function is not resident is refused. ctx_miss is then high in the following cycle only. ctx_miss stays low after an issue of a resident function.
- R8: The resident set has CTX_WAYS contexts (4 by default). Valid function numbers are 0 to 13. A load of 14 or 15 is ignored, and an issue of 14 or 15 always misses. A load of a non-resident function replaces the least recently used context. Recency is refreshed by a load of that function, or by an accepted issue of it.
- R9: cpu_stall is low whenever cpu_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Processor access present |
| cpu_is_store | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | AW | Processor access address |
| cpu_stall | output | 1 | Access conflicts with a busy region (combinational) |
| iss_valid | input | 1 | Array operation issue request |
| iss_fn | input | 4 | Function number of the request |
| iss_src | input | AW | Source block base |
| iss_dst | input | AW | Destination block base |
| iss_lg | input | 5 | log2 of the block size |
| iss_accept | output | 1 | Request accepted this cycle (combinational) |
| iss_slot | output | IW | Slot an accepted request occupies |
| done_valid | input | 1 | Operation completion |
| done_idx | input | IW | Slot of the completed operation |
| ld_valid | input | 1 | Context load request |
| ld_fn | input | 4 | Function to make resident |
| ctx_miss | output | 1 | Previous cycle issued a non-resident function (registered) |

## Verification
The hardest state to reach is the moment of least-recently-used replacement. Its victim depends on the full history of context loads and accepted issues. Refused issues must leave that history untouched. The stimulus first fills every context, then accepts issues in a known order to fix the recency ranking. It then loads a new function and probes both the evicted function and a survivor through ctx_miss. For the survivor, the table is deliberately full, so a low ctx_miss shows that the context is resident rather than that the issue was accepted. A second corner is a completion, a conflicting access and a new issue all in one cycle. This is driven as a single combined cycle to show that the freed slot neither blocks nor stays occupied.

// File: rtl/rsb_pkg.sv
package rsb_pkg;
  localparam int unsigned FN_W     = 4;
  localparam int unsigned LG_W     = 5;
  localparam int unsigned FN_LIMIT = 14;
  typedef logic [FN_W-1:0] fn_t;
  typedef logic [LG_W-1:0] lg_t;
endpackage

// File: rtl/rsb_region_overlap.sv
module rsb_region_overlap
  import rsb_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] a_base,
  input  lg_t           a_lg,
  input  logic [AW-1:0] b_base,
  input  lg_t           b_lg,
  output logic          hit
);
  logic [AW-1:0] ones;
  logic [AW-1:0] keep;
  lg_t           wide;

  always_comb begin
    ones = '1;
    wide = (a_lg > b_lg) ? a_lg : b_lg;
    keep = ones << wide;
    hit  = ((a_base ^ b_base) & keep) == '0;
  end
endmodule

// File: rtl/rsb_ctx_resident.sv
module rsb_ctx_resident
  import rsb_pkg::*;
#(
  parameter int unsigned WAYS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic ld_valid,
  input  fn_t  ld_fn,
  input  fn_t  q_fn,
  input  logic touch_q,
  output logic q_hit
);
  localparam int unsigned WIW = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic           way_vld [WAYS];
  fn_t            way_fn  [WAYS];
  logic [WIW-1:0] way_age [WAYS];

  logic           q_any, ld_hit, ld_ok, fill, touch_en;
  logic [WIW-1:0] q_way, ld_way, victim, touch_way, touch_age;

  always_comb begin
    q_any  = 1'b0;
    q_way  = '0;
    ld_hit = 1'b0;
    ld_way = '0;
    victim = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (way_vld[w] && way_fn[w] == q_fn) begin
        q_any = 1'b1;
        q_way = WIW'(w);
      end
      if (way_vld[w] && way_fn[w] == ld_fn) begin
        ld_hit = 1'b1;
        ld_way = WIW'(w);
      end
      if (way_age[w] == WIW'(WAYS - 1)) victim = WIW'(w);
    end
    q_hit = q_any && (int'(q_fn) < int'(FN_LIMIT));
  end

  always_comb begin
    ld_ok     = ld_valid && (int'(ld_fn) < int'(FN_LIMIT));
    fill      = ld_ok && !ld_hit;
    touch_en  = ld_ok || (touch_q && q_hit);
    touch_way = ld_ok ? (ld_hit ? ld_way : victim) : q_way;
    touch_age = way_age[touch_way];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int w = 0; w < WAYS; w++) begin
        way_vld[w] <= 1'b0;
        way_age[w] <= WIW'(w);
      end
    end else begin
      if (touch_en) begin
        for (int w = 0; w < WAYS; w++) begin
          if (WIW'(w) == touch_way) way_age[w] <= '0;
          else if (way_age[w] < touch_age) way_age[w] <= way_age[w] + 1'b1;
        end
      end
      if (fill) way_vld[touch_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill) way_fn[touch_way] <= ld_fn;
  end
endmodule

// File: rtl/region_scoreboard.sv
module region_scoreboard
  import rsb_pkg::*;
#(
  parameter int unsigned AW       = 32,
  parameter int unsigned NUM_OPS  = 4,
  parameter int unsigned CTX_WAYS = 4,
  localparam int unsigned IW      = (NUM_OPS > 1) ? $clog2(NUM_OPS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cpu_valid,
  input  logic          cpu_is_store,
  input  logic [AW-1:0] cpu_addr,
  output logic          cpu_stall,
  input  logic          iss_valid,
  input  logic [3:0]    iss_fn,
  input  logic [AW-1:0] iss_src,
  input  logic [AW-1:0] iss_dst,
  input  logic [4:0]    iss_lg,
  output logic          iss_accept,
  output logic [IW-1:0] iss_slot,
  input  logic          done_valid,
  input  logic [IW-1:0] done_idx,
  input  logic          ld_valid,
  input  logic [3:0]    ld_fn,
  output logic          ctx_miss
);
  logic          ent_vld [NUM_OPS];
  logic [AW-1:0] ent_src [NUM_OPS];
  logic [AW-1:0] ent_dst [NUM_OPS];
  lg_t           ent_lg  [NUM_OPS];

  logic [NUM_OPS-1:0] live, c_src, c_dst, h_raw, h_war, h_waw;
  logic               ctx_hit, free_found, hazard;
  logic [IW-1:0]      free_idx;

  for (genvar i = 0; i < NUM_OPS; i++) begin : g_ent
    assign live[i] = ent_vld[i] && !(done_valid && done_idx == IW'(i));

    rsb_region_overlap #(.AW(AW)) u_cs (
      .a_base(cpu_addr), .a_lg('0), .b_base(ent_src[i]), .b_lg(ent_lg[i]), .hit(c_src[i]));
    rsb_region_overlap #(.AW(AW)) u_cd (
      .a_base(cpu_addr), .a_lg('0), .b_base(ent_dst[i]), .b_lg(ent_lg[i]), .hit(c_dst[i]));
    rsb_region_overlap #(.AW(AW)) u_raw (
      .a_base(iss_src), .a_lg(iss_lg), .b_base(ent_dst[i]), .b_lg(ent_lg[i]), .hit(h_raw[i]));
    rsb_region_overlap #(.AW(AW)) u_war (
      .a_base(iss_dst), .a_lg(iss_lg), .b_base(ent_src[i]), .b_lg(ent_lg[i]), .hit(h_war[i]));
    rsb_region_overlap #(.AW(AW)) u_waw (
      .a_base(iss_dst), .a_lg(iss_lg), .b_base(ent_dst[i]), .b_lg(ent_lg[i]), .hit(h_waw[i]));
  end

  rsb_ctx_resident #(.WAYS(CTX_WAYS)) u_ctx (
    .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_fn(ld_fn),
    .q_fn(iss_fn), .touch_q(iss_accept), .q_hit(ctx_hit));

  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    for (int i = NUM_OPS - 1; i >= 0; i--) begin
      if (!live[i]) begin
        free_found = 1'b1;
        free_idx   = IW'(i);
      end
    end
  end

  always_comb begin
    hazard     = |(live & (h_raw | h_war | h_waw));
    cpu_stall  = cpu_valid && |(live & (c_dst | (cpu_is_store ? c_src : '0)));
    iss_accept = iss_valid && ctx_hit && free_found && !hazard;
    iss_slot   = free_idx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_OPS; i++) ent_vld[i] <= 1'b0;
      ctx_miss <= 1'b0;
    end else begin
      for (int i = 0; i < NUM_OPS; i++) begin
        if (iss_accept && free_idx == IW'(i)) ent_vld[i] <= 1'b1;
        else if (done_valid && done_idx == IW'(i)) ent_vld[i] <= 1'b0;
      end
      ctx_miss <= iss_valid && !ctx_hit;
    end
  end

  always_ff @(posedge clk) begin
    if (iss_accept) begin
      ent_src[free_idx] <= iss_src;
      ent_dst[free_idx] <= iss_dst;
      ent_lg[free_idx]  <= iss_lg;
    end
  end
endmodule

// File: rtl/rsb_checker.sv
module rsb_checker #(
  parameter int unsigned AW = 32,
  parameter int unsigned IW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          cpu_valid,
  input logic          cpu_is_store,
  input logic [AW-1:0] cpu_addr,
  input logic          cpu_stall,
  input logic          iss_valid,
  input logic [3:0]    iss_fn,
  input logic [AW-1:0] iss_dst,
  input logic          iss_accept,
  input logic [IW-1:0] iss_slot,
  input logic          done_valid,
  input logic [IW-1:0] done_idx,
  input logic          ctx_miss
);
  assert_idle_no_stall_R9: assert property (@(posedge clk) disable iff (rst)
    !cpu_valid |-> !cpu_stall);

  assert_accept_needs_request_R5: assert property (@(posedge clk) disable iff (rst)
    iss_accept |-> iss_valid);

  assert_accept_fn_range_R8: assert property (@(posedge clk) disable iff (rst)
    iss_accept |-> (iss_fn < 4'd14));

  assert_miss_follows_issue_R7: assert property (@(posedge clk) disable iff (rst)
    ctx_miss |-> $past(iss_valid));

  assert_new_dst_busy_R2: assert property (@(posedge clk) disable iff (rst)
    (iss_accept && !(done_valid && done_idx == iss_slot)) |=>
      (!(cpu_valid && !cpu_is_store && cpu_addr == $past(iss_dst)) ||
       (done_valid && done_idx == $past(iss_slot)) || cpu_stall));
endmodule

bind region_scoreboard rsb_checker #(.AW(AW), .IW(IW)) u_chk (.*);

// File: tb/tb_region_scoreboard.sv
module tb_region_scoreboard;
  localparam int CLK_P = 10;
  localparam int AW    = 32;
  localparam int IW    = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cpu_valid = 0, cpu_is_store = 0;
  logic [AW-1:0] cpu_addr = '0;
  logic          cpu_stall;
  logic          iss_valid = 0;
  logic [3:0]    iss_fn = '0;
  logic [AW-1:0] iss_src = '0, iss_dst = '0;
  logic [4:0]    iss_lg = '0;
  logic          iss_accept;
  logic [IW-1:0] iss_slot;
  logic          done_valid = 0;
  logic [IW-1:0] done_idx = '0;
  logic          ld_valid = 0;
  logic [3:0]    ld_fn = '0;
  logic          ctx_miss;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  region_scoreboard dut (.*);

  always #(CLK_P/2) clk = ~clk;

  // {is_store, addr, expected stall} with entry src 0x1000, dst 0x2000, exponent 8
  localparam logic [33:0] VEC [9] = '{
    {1'b0, 32'h0000_1000, 1'b0},
    {1'b1, 32'h0000_1080, 1'b1},
    {1'b0, 32'h0000_20FF, 1'b1},
    {1'b0, 32'h0000_2100, 1'b0},
    {1'b1, 32'h0000_2040, 1'b1},
    {1'b1, 32'h0000_1100, 1'b0},
    {1'b0, 32'h0000_10FF, 1'b0},
    {1'b1, 32'h0000_0FFF, 1'b0},
    {1'b0, 32'h0000_2000, 1'b1}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic probe(input logic vld, input logic st, input logic [AW-1:0] a,
                       input logic exp, input string tag);
    @(negedge clk);
    cpu_valid = vld; cpu_is_store = st; cpu_addr = a;
    #2;
    check(tag, 32'(cpu_stall), 32'(exp));
    cpu_valid = 0;
  endtask

  task automatic issue(input logic [3:0] f, input logic [AW-1:0] s, input logic [AW-1:0] d,
                       input logic [4:0] l, input logic exp_acc, input logic [IW-1:0] exp_slot,
                       input string tag);
    @(negedge clk);
    iss_valid = 1; iss_fn = f; iss_src = s; iss_dst = d; iss_lg = l;
    #2;
    check({tag, " accept"}, 32'(iss_accept), 32'(exp_acc));
    if (exp_acc) check({tag, " slot"}, 32'(iss_slot), 32'(exp_slot));
    @(posedge clk); #1;
    iss_valid = 0;
  endtask

  task automatic miss_is(input logic exp, input string tag);
    @(negedge clk);
    check(tag, 32'(ctx_miss), 32'(exp));
  endtask

  task automatic load(input logic [3:0] f);
    @(negedge clk);
    ld_valid = 1; ld_fn = f;
    @(posedge clk); #1;
    ld_valid = 0;
  endtask

  task automatic retire(input logic [IW-1:0] idx);
    @(negedge clk);
    done_valid = 1; done_idx = idx;
    @(posedge clk); #1;
    done_valid = 0;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;

    // R1: empty after reset
    probe(1, 0, 32'h0, 0, "R1 load after reset");
    probe(1, 1, 32'h2000, 0, "R1 store after reset");
    issue(4'd1, 32'h1000, 32'h2000, 5'd8, 0, 0, "R1 issue with no contexts");
    miss_is(1, "R7 miss pulse after reset issue");
    miss_is(0, "R7 miss lasts one cycle");

    // contexts: 1,2,3,4 resident
    load(4'd1); load(4'd2); load(4'd3); load(4'd4);
    issue(4'd1, 32'h1000, 32'h2000, 5'd8, 1, 2'd0, "R7 resident issue A");
    miss_is(0, "R7 no miss for resident");

    // R2/R3 vector walk
    for (int k = 0; k < 9; k++)
      probe(1, VEC[k][33], VEC[k][32:1], VEC[k][0], $sformatf("R2 R3 vector %0d", k));

    // R4 hazards
    issue(4'd2, 32'h2080, 32'h5000, 5'd4, 0, 0, "R4 RAW refused");
    issue(4'd2, 32'h6000, 32'h1000, 5'd4, 0, 0, "R4 WAR refused");
    issue(4'd2, 32'h6000, 32'h2000, 5'd12, 0, 0, "R4 WAW refused");
    issue(4'd2, 32'h1000, 32'h3000, 5'd4, 1, 2'd1, "R4 read-read accepted");
    issue(4'd2, 32'h7000, 32'h0000, 5'd16, 0, 0, "R3 larger exponent overlap refused");

    // R5 fill and full
    issue(4'd3, 32'h8000, 32'h9000, 5'd4, 1, 2'd2, "R5 third slot");
    issue(4'd4, 32'hA000, 32'hB000, 5'd4, 1, 2'd3, "R5 fourth slot");
    issue(4'd1, 32'hC000, 32'hD000, 5'd4, 0, 0, "R5 full refused");

    // R6 retire, conflicting access and issue in one cycle
    @(negedge clk);
    done_valid = 1; done_idx = 2'd0;
    cpu_valid = 1; cpu_is_store = 0; cpu_addr = 32'h2000;
    iss_valid = 1; iss_fn = 4'd1; iss_src = 32'hC000; iss_dst = 32'hD000; iss_lg = 5'd4;
    #2;
    check("R6 retired entry no longer stalls", 32'(cpu_stall), 32'd0);
    check("R6 freed slot accepted", 32'(iss_accept), 32'd1);
    check("R6 freed slot reused", 32'(iss_slot), 32'd0);
    @(posedge clk); #1;
    done_valid = 0; cpu_valid = 0; iss_valid = 0;
    probe(1, 0, 32'hD00C, 1, "R6 new entry busy");
    probe(1, 0, 32'h2000, 0, "R6 old entry gone");
    retire(2'd2);
    probe(1, 0, 32'h9000, 0, "R6 slot 2 retired");
    probe(1, 0, 32'hB000, 1, "R6 slot 3 untouched");

    // R8 LRU: recency now 1,4,3,2 -> loading 5 evicts 2
    load(4'd5);
    issue(4'd2, 32'h10000, 32'h11000, 5'd4, 0, 0, "R8 evicted function refused");
    miss_is(1, "R8 evicted function misses");
    issue(4'd5, 32'hE000, 32'hF000, 5'd4, 1, 2'd2, "R8 loaded function accepted");
    miss_is(0, "R8 loaded function no miss");
    load(4'd1);
    load(4'd6);
    issue(4'd3, 32'h20000, 32'h21000, 5'd4, 0, 0, "R8 LRU victim refused");
    miss_is(1, "R8 LRU victim misses");
    issue(4'd4, 32'h20000, 32'h21000, 5'd4, 0, 0, "R5 full while resident");
    miss_is(0, "R8 survivor still resident");
    load(4'd14);
    issue(4'd14, 32'h20000, 32'h21000, 5'd4, 0, 0, "R8 function 14 refused");
    miss_is(1, "R8 function 14 misses");
    issue(4'd4, 32'h20000, 32'h21000, 5'd4, 0, 0, "R8 after ignored load");
    miss_is(0, "R8 ignored load evicted nothing");

    // R9
    probe(0, 1, 32'hD000, 0, "R9 idle access never stalls");
    probe(1, 1, 32'hD000, 1, "R2 same address when valid");

    finish_run();
  end
endmodule